// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase-shifted channels of an incremental rotary or linear encoder into a signed 32-bit position. Both channels and the index line arrive already synchronised to the block clock. Each clock edge samples them once. A four-state phase tracker classifies the move since the previous sample as one of four moves: no change, a forward step, a reverse step, or an illegal jump. A mode setting then picks which legal steps reach the counter, so there are one, two or four counts per encoder cycle.

The index line can put the counter back to a programmed value. This happens only while the index is enabled and the sampled channel pair equals one selected phase out of the four in the cycle. This gives a repeatable home position. A strobe copies the current count into a held register for an on-demand read. An illegal jump, with both channels changing between two samples, leaves the count untouched and raises a flag that stays set until reset.

The phase tracker has four states named after the channel pair {A,B}: PH_00, PH_10, PH_11 and PH_01. It has four moves. FWD is the step PH_00→PH_10→PH_11→PH_01→PH_00, in which A leads B. REV is the same ring walked the other way. HOLD is a sample equal to the state. SKIP is a jump to the diagonal state. After every sample, including samples taken during reset, the tracker takes the state of the sampled pair.

Top module: `quad_pos_counter`

## Requirements
- R1: The counting modes are encoded on `cnt_mode` as 0 for one count per cycle, 1 for two counts per cycle, 2 for four counts per cycle, and 3, which behaves as 2. In four-count mode every FWD move adds one and every REV move subtracts one.
- R2: In two-count mode only moves that toggle A count. These are up on 00→10 and 11→01, and down on 10→00 and 01→11, with pairs written {A,B}. Moves that toggle only B leave the count unchanged.
- R3: In one-count mode the count rises only on 00→10 and falls only on 10→00. All other moves leave it unchanged, so a full cycle forward and back returns to the start value.
- R4: Code 3 on `cnt_mode` counts exactly as four-count mode, including B-only moves.
- R5: A SKIP move, where A and B both change between two samples, leaves the count unchanged and sets `seq_err`. `seq_err` stays at 1 until reset.
- R6: When `idx_en` is 1, `chan_z` is 1 and {`chan_a`,`chan_b`} equals `idx_phase` (bit 1 compared with A, bit 0 with B) at a clock edge, the count after that edge equals `home_val`. This reload takes precedence over any step on the same edge.
- R7: `chan_z` has no effect on the count when `idx_en` is 0 or when the sampled pair differs from `idx_phase`. The normal step still applies in those cases.
- R8: The count is 32-bit two's complement and wraps: adding one to 0xFFFFFFFF gives 0, and subtracting one from 0 gives 0xFFFFFFFF.
- R9: When `snap` is 1 at a clock edge, `pos_held` takes the value that `pos_live` had just before that edge. Otherwise `pos_held` keeps its value.
- R10: Reset (`rst`, synchronous, active high) gives `pos_live` = `home_val`, `pos_held` = 0 and `seq_err` = 0. The first sample after reset counts nothing unless the channels moved.
- R11: Channels are sampled at each rising clock edge, and `pos_live` reflects a move right after the edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_a | input | 1 | Encoder channel A, synchronised |
| chan_b | input | 1 | Encoder channel B, synchronised |
| chan_z | input | 1 | Index channel, synchronised |
| cnt_mode | input | 2 | Counting mode: 0 one, 1 two, 2 or 3 four counts per cycle |
| home_val | input | 32 | Value loaded by reset and by an index reload |
| idx_phase | input | 2 | Phase {A,B} in which the index may reload |
| idx_en | input | 1 | Enables index reload |
| snap | input | 1 | Latch strobe for the held position |
| pos_live | output | 32 | Running position |
| pos_held | output | 32 | Position captured by the last strobe |
| seq_err | output | 1 | Sticky illegal-transition flag |

## Verification
Several properties are checked on every cycle. The count never moves by more than one. The base edges 00→10 and 10→00 step up and down in every mode. A reload always lands on the programmed value. A SKIP move holds the count, and the error flag never drops outside reset. The held register copies the prior count, and reset loads the home value. Only the bench's scenarios can show the rest. This covers how each mode filters the other edges, wrap-around at the 32-bit limit, the reserved mode code, and index pulses ignored when disabled or in the wrong phase. It also covers whole forward-and-back sequences that return to the start value.

// File: rtl/quad_pos_pkg.sv
package quad_pos_pkg;

    // Phase state encoded as {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } qphase_t;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_FWD  = 2'd1,
        MV_REV  = 2'd2,
        MV_SKIP = 2'd3
    } qmove_t;

    typedef enum logic [1:0] {
        CM_ONE  = 2'd0,
        CM_TWO  = 2'd1,
        CM_FOUR = 2'd2,
        CM_RSVD = 2'd3
    } cmode_t;

    // Successor of a phase when A leads B
    function automatic qphase_t fwd_next(input qphase_t s);
        qphase_t n;
        case (s)
            PH_00:   n = PH_10;
            PH_10:   n = PH_11;
            PH_11:   n = PH_01;
            default: n = PH_00;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/quad_phase_fsm.sv
module quad_phase_fsm
    import quad_pos_pkg::*;
(
    input  logic    clk,
    input  logic    ch_a,
    input  logic    ch_b,
    output qphase_t ph_prev,
    output qphase_t ph_now,
    output qmove_t  move
);

    qphase_t state_q;
    qphase_t obs;

    assign obs = qphase_t'({ch_a, ch_b});

    // State register: always follows the sampled pair, also during reset
    always_ff @(posedge clk) begin
        state_q <= obs;
    end

    // Move classification
    always_comb begin
        if (obs == state_q)
            move = MV_HOLD;
        else if (obs == fwd_next(state_q))
            move = MV_FWD;
        else if (state_q == fwd_next(obs))
            move = MV_REV;
        else
            move = MV_SKIP;
    end

    assign ph_prev = state_q;
    assign ph_now  = obs;

endmodule

// File: rtl/quad_step_sel.sv
module quad_step_sel
    import quad_pos_pkg::*;
(
    input  logic [1:0] mode_raw,
    input  qphase_t    ph_prev,
    input  qphase_t    ph_now,
    input  qmove_t     move,
    output logic       inc,
    output logic       dec
);

    cmode_t mode;
    logic   is_fwd;
    logic   is_rev;
    logic   a_flip;

    assign mode   = cmode_t'(mode_raw);
    assign is_fwd = (move == MV_FWD);
    assign is_rev = (move == MV_REV);
    assign a_flip = (ph_prev[1] != ph_now[1]);

    always_comb begin
        unique case (mode)
            CM_ONE: begin
                inc = is_fwd && (ph_prev == PH_00);
                dec = is_rev && (ph_prev == PH_10);
            end
            CM_TWO: begin
                inc = is_fwd && a_flip;
                dec = is_rev && a_flip;
            end
            CM_FOUR, CM_RSVD: begin
                inc = is_fwd;
                dec = is_rev;
            end
        endcase
    end

endmodule

// File: rtl/quad_count_reg.sv
module quad_count_reg #(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] home_val,
    input  logic             reload,
    input  logic             inc,
    input  logic             dec,
    input  logic             skip,
    input  logic             snap,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] held,
    output logic             err
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            pos <= home_val;
        else if (reload)
            pos <= home_val;
        else if (inc)
            pos <= pos + ONE;
        else if (dec)
            pos <= pos - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            err <= 1'b0;
        else if (skip)
            err <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (snap)
            held <= pos;
    end

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import quad_pos_pkg::*;
#(
    parameter int POS_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_a,
    input  logic             chan_b,
    input  logic             chan_z,
    input  logic [1:0]       cnt_mode,
    input  logic [POS_W-1:0] home_val,
    input  logic [1:0]       idx_phase,
    input  logic             idx_en,
    input  logic             snap,
    output logic [POS_W-1:0] pos_live,
    output logic [POS_W-1:0] pos_held,
    output logic             seq_err
);

    qphase_t ph_prev;
    qphase_t ph_now;
    qmove_t  move;
    logic    inc;
    logic    dec;
    logic    reload;

    quad_phase_fsm u_fsm (
        .clk     (clk),
        .ch_a    (chan_a),
        .ch_b    (chan_b),
        .ph_prev (ph_prev),
        .ph_now  (ph_now),
        .move    (move)
    );

    quad_step_sel u_sel (
        .mode_raw (cnt_mode),
        .ph_prev  (ph_prev),
        .ph_now   (ph_now),
        .move     (move),
        .inc      (inc),
        .dec      (dec)
    );

    assign reload = idx_en && chan_z && (ph_now == qphase_t'(idx_phase));

    quad_count_reg #(.POS_W(POS_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .home_val (home_val),
        .reload   (reload),
        .inc      (inc),
        .dec      (dec),
        .skip     (move == MV_SKIP),
        .snap     (snap),
        .pos      (pos_live),
        .held     (pos_held),
        .err      (seq_err)
    );

endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
    parameter int POS_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             chan_a,
    input logic             chan_b,
    input logic             chan_z,
    input logic [POS_W-1:0] home_val,
    input logic [1:0]       idx_phase,
    input logic             idx_en,
    input logic             snap,
    input logic [POS_W-1:0] pos_live,
    input logic [POS_W-1:0] pos_held,
    input logic             seq_err
);

    localparam logic [POS_W-1:0] ONE = POS_W'(1);

    logic [1:0] ab_d;
    logic [1:0] ab;
    logic       hit;

    assign ab  = {chan_a, chan_b};
    assign hit = idx_en && chan_z && (ab == idx_phase);

    always_ff @(posedge clk) begin
        ab_d <= ab;
    end

    AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit)) |->
        (pos_live == $past(pos_live) || pos_live == $past(pos_live) + ONE ||
         pos_live == $past(pos_live) - ONE)); // R1

    AST_BASE_UP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit) && $past(ab_d) == 2'b00 && $past(ab) == 2'b10)
        |-> pos_live == $past(pos_live) + ONE); // R3

    AST_BASE_DN: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit) && $past(ab_d) == 2'b10 && $past(ab) == 2'b00)
        |-> pos_live == $past(pos_live) - ONE); // R2

    AST_SKIP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit) && ($past(ab_d) ^ $past(ab)) == 2'b11)
        |-> (pos_live == $past(pos_live) && seq_err)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(seq_err)) |-> seq_err); // R5

    AST_Z_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit)) |-> pos_live == $past(home_val)); // R6

    AST_SNAP_VALUE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(snap)) |-> pos_held == $past(pos_live)); // R9

    AST_RESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pos_live == $past(home_val) && pos_held == '0 && !seq_err)); // R10

endmodule

bind quad_pos_counter quad_pos_counter_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .chan_a    (chan_a),
    .chan_b    (chan_b),
    .chan_z    (chan_z),
    .home_val  (home_val),
    .idx_phase (idx_phase),
    .idx_en    (idx_en),
    .snap      (snap),
    .pos_live  (pos_live),
    .pos_held  (pos_held),
    .seq_err   (seq_err)
);

// File: tb/sim_quad_pos_counter.sv
module sim_quad_pos_counter;

    localparam int CLK_P = 10;
    localparam int NV    = 12;

    // Vector fields: {A, B, expected err, expected pos}; four-count mode, home 100
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 32'd101},
        {1'b1, 1'b1, 1'b0, 32'd102},
        {1'b0, 1'b1, 1'b0, 32'd103},
        {1'b0, 1'b0, 1'b0, 32'd104},
        {1'b0, 1'b1, 1'b0, 32'd103},
        {1'b1, 1'b1, 1'b0, 32'd102},
        {1'b1, 1'b1, 1'b0, 32'd102},
        {1'b1, 1'b0, 1'b0, 32'd101},
        {1'b0, 1'b0, 1'b0, 32'd100},
        {1'b1, 1'b1, 1'b1, 32'd100},
        {1'b0, 1'b1, 1'b1, 32'd101},
        {1'b0, 1'b0, 1'b1, 32'd102}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_a = 1'b0;
    logic        chan_b = 1'b0;
    logic        chan_z = 1'b0;
    logic [1:0]  cnt_mode = 2'd2;
    logic [31:0] home_val = 32'd100;
    logic [1:0]  idx_phase = 2'b00;
    logic        idx_en = 1'b0;
    logic        snap = 1'b0;
    logic [31:0] pos_live;
    logic [31:0] pos_held;
    logic        seq_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    quad_pos_counter u0 (
        .clk       (clk),
        .rst       (rst),
        .chan_a    (chan_a),
        .chan_b    (chan_b),
        .chan_z    (chan_z),
        .cnt_mode  (cnt_mode),
        .home_val  (home_val),
        .idx_phase (idx_phase),
        .idx_en    (idx_en),
        .snap      (snap),
        .pos_live  (pos_live),
        .pos_held  (pos_held),
        .seq_err   (seq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic b, input logic z, input logic s);
        @(negedge clk);
        chan_a = a; chan_b = b; chan_z = z; snap = s;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [31:0] hv, input logic [1:0] md);
        @(negedge clk);
        rst = 1'b1; home_val = hv; cnt_mode = md;
        chan_a = 1'b0; chan_b = 1'b0; chan_z = 1'b0; snap = 1'b0;
        idx_en = 1'b0; idx_phase = 2'b00;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state, with a prior error cleared later
        do_reset(32'd100, 2'd2);
        chk("R10 pos", pos_live, 32'd100);
        chk("R10 held", pos_held, 32'd0);
        chk("R10 err", {31'd0, seq_err}, 32'd0);

        // R1 R5 R11: vector table in four-count mode
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][34], VEC[i][33], 1'b0, 1'b0);
            chk("R1 vec pos", pos_live, VEC[i][31:0]);
            chk("R5 vec err", {31'd0, seq_err}, {31'd0, VEC[i][32]});
        end

        // R10: reset clears the sticky flag
        do_reset(32'd0, 2'd0);
        chk("R10 err cleared", {31'd0, seq_err}, 32'd0);

        // R3: one-count mode
        step(1, 0, 0, 0);
        chk("R3 first edge", pos_live, 32'd1);
        step(1, 1, 0, 0); step(0, 1, 0, 0); step(0, 0, 0, 0);
        chk("R3 full fwd cycle", pos_live, 32'd1);
        step(0, 1, 0, 0); step(1, 1, 0, 0); step(1, 0, 0, 0);
        chk("R3 rev before A fall", pos_live, 32'd1);
        step(0, 0, 0, 0);
        chk("R3 rev back to start", pos_live, 32'd0);

        // R2: two-count mode
        do_reset(32'd0, 2'd1);
        step(1, 0, 0, 0); step(1, 1, 0, 0);
        chk("R2 B edge ignored", pos_live, 32'd1);
        step(0, 1, 0, 0); step(0, 0, 0, 0);
        chk("R2 full fwd cycle", pos_live, 32'd2);
        step(0, 1, 0, 0);
        chk("R2 rev B edge ignored", pos_live, 32'd2);
        step(1, 1, 0, 0); step(1, 0, 0, 0); step(0, 0, 0, 0);
        chk("R2 rev back to start", pos_live, 32'd0);

        // R4: reserved code counts as four-count
        do_reset(32'd0, 2'd3);
        step(1, 0, 0, 0); step(1, 1, 0, 0);
        chk("R4 code 3 counts B edge", pos_live, 32'd2);

        // R8: wrap both ways
        do_reset(32'hFFFF_FFFF, 2'd2);
        step(1, 0, 0, 0);
        chk("R8 wrap up", pos_live, 32'd0);
        step(0, 0, 0, 0);
        chk("R8 wrap down", pos_live, 32'hFFFF_FFFF);

        // R6 R7: index reload qualified by phase {A,B}
        do_reset(32'd500, 2'd2);
        idx_en = 1'b1; idx_phase = 2'b11;
        step(1, 0, 1, 0);
        chk("R7 wrong phase", pos_live, 32'd501);
        step(1, 1, 1, 0);
        chk("R6 reload at phase 11", pos_live, 32'd500);
        step(0, 1, 0, 0);
        chk("R6 count after reload", pos_live, 32'd501);
        idx_en = 1'b0; idx_phase = 2'b00;
        step(0, 0, 1, 0);
        chk("R7 disabled index", pos_live, 32'd502);
        idx_en = 1'b1; idx_phase = 2'b10;
        step(1, 0, 1, 0);
        chk("R6 reload beats step", pos_live, 32'd500);

        // R9: snapshot takes pre-edge value
        step(1, 1, 0, 1);
        chk("R9 count moved", pos_live, 32'd501);
        chk("R9 held old value", pos_held, 32'd500);
        step(1, 1, 0, 0);
        chk("R9 held kept", pos_held, 32'd500);
        step(1, 1, 0, 1);
        chk("R9 held refresh", pos_held, 32'd501);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule